// File: doc/BRIEF.md
# Either-Edge Pin Event Status with Shared SMI

This block watches four general-purpose input pins. It turns any transition on them, rising or falling, into sticky event flags in a byte-wide status register. Each pin first passes through a two-flop synchroniser. An edge is the difference between the current synchronised value and the value one cycle earlier.

A second byte-wide register holds one enable bit per source. Any flagged source whose enable bit is set pulls the single active-low SMI line low. Software reads the status register to find the cause of the interrupt. It then writes ones to the flags it has handled.

Both registers sit behind a plain register port made of an address, a write strobe, write data and combinational read data. Status is at address 0 and enable is at address 1. All other addresses are empty.

Top module: `gpio_edge_smi`

## Requirements
- R1: After reset, status (address 0) and enable (address 1) both read 0x00 and `smi_n_o` is high.
- R2: A rising edge on a pin sets its status flag. The pin-to-bit mapping is pin 0 to bit 0, pin 1 to bit 1, pin 2 to bit 4 and pin 3 to bit 5.
- R3: A falling edge on a pin sets its status flag in the same way as a rising edge.
- R4: Take a pin change that is stable before a rising clock edge. Its flag reads as set after the third rising edge, and it still reads clear after the second.
- R5: Writing to address 0 clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R6: Status bits 2, 3, 6 and 7 always read zero, and writes to them have no effect.
- R7: The enable register at address 1 is read/write in bits 0, 1, 4 and 5. Its other bits read zero.
- R8: `smi_n_o` is low exactly when the bitwise AND of status and enable is nonzero.
- R9: An edge that is detected in the same cycle as a write-1 clear of its flag leaves the flag set.
- R10: Addresses 2 and 3 read 0x00, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 4 | Asynchronous general-purpose inputs |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| smi_n_o | output | 1 | Active-low shared interrupt |

## Verification
The directed patterns cover several distinct cases:
- A rising edge and a falling edge, which tell apart one-sided edge detection and either-edge detection.
- A simultaneous fall on one pin and rise on another, which exposes a wrong pin-to-bit map.
- Reads taken after the second and third clock edges, which separate a correct synchroniser depth from a shorter or longer one.
- A clear written in the exact cycle an edge is detected, which shows whether set or clear has priority.
- Enable masks that include or exclude the pending source, which separate AND gating from plain OR.

Random stretches of sparse pin toggles, mixed with random reads and writes at all four addresses, are then checked cycle by cycle against a reference model in the bench.

// File: rtl/gpevt_pkg.sv
package gpevt_pkg;
    localparam int REG_W   = 8;
    localparam int NUM_SRC = 4;

    // bits that hold state in both registers
    localparam logic [REG_W-1:0] LIVE_MASK = 8'h33;

    // status bit position used by each source
    function automatic int src_bit(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            2:       return 4;
            default: return 5;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] spread(input logic [NUM_SRC-1:0] v);
        logic [REG_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_SRC; i++) r[src_bit(i)] = v[i];
        return r;
    endfunction

    typedef struct packed {
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] en;
    } evt_regs_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], pin_i};
        sync_d.last  = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign edge_o = sync_q.chain[STAGES-1] ^ sync_q.last;
endmodule

// File: rtl/evt_regs.sv
module evt_regs
    import gpevt_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] edge_i,
    input  logic               st_wr_i,
    input  logic               en_wr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   stat_o,
    output logic [REG_W-1:0]   en_o
);
    evt_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (st_wr_i) regs_d.stat = regs_q.stat & ~(wdata_i & LIVE_MASK);
        // a fresh edge overrides a clear in the same cycle
        regs_d.stat = regs_d.stat | spread(edge_i);
        if (en_wr_i) regs_d.en = wdata_i & LIVE_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign stat_o = regs_q.stat;
    assign en_o   = regs_q.en;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        localparam int P = src_bit(g);

        p_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            edge_i[g] |=> regs_q.stat[P]);

        p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_wr_i && wdata_i[P] && !edge_i[g]) |=> !regs_q.stat[P]);

        p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!edge_i[g] && !(st_wr_i && wdata_i[P])) |=> $stable(regs_q.stat[P]));
    end

    p_enable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_wr_i |=> (regs_q.en == ($past(wdata_i) & LIVE_MASK)));
endmodule

// File: rtl/gpio_edge_smi.sv
module gpio_edge_smi
    import gpevt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] pins_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   rdata_o,
    output logic               smi_n_o
);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_EN   = ADDR_W'(1);

    logic [NUM_SRC-1:0] edge_w;
    logic [REG_W-1:0]   stat_w, en_w;
    logic               st_wr, en_wr;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pin
        edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .pin_i  (pins_i[g]),
            .edge_o (edge_w[g])
        );
    end

    assign st_wr = wr_i && (addr_i == ADDR_STAT);
    assign en_wr = wr_i && (addr_i == ADDR_EN);

    evt_regs u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .edge_i  (edge_w),
        .st_wr_i (st_wr),
        .en_wr_i (en_wr),
        .wdata_i (wdata_i),
        .stat_o  (stat_w),
        .en_o    (en_w)
    );

    always_comb begin
        unique case (addr_i)
            ADDR_STAT: rdata_o = stat_w;
            ADDR_EN:   rdata_o = en_w;
            default:   rdata_o = '0;
        endcase
    end

    assign smi_n_o = ~|(stat_w & en_w);

    p_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_w == '0) |-> smi_n_o);
endmodule

// File: tb/gpio_edge_smi_test.sv
module gpio_edge_smi_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst_n = 0;
    logic [3:0] pins = 0;
    logic [1:0] addr = 0;
    logic       wr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       smi_n;

    gpio_edge_smi uut (
        .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .addr_i(addr),
        .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .smi_n_o(smi_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_run = 0, n_fail = 0;

    function automatic logic [7:0] map_bits(input logic [3:0] v);
        return {2'b00, v[3], v[2], 2'b00, v[1], v[0]};
    endfunction

    // reference model, updated at each rising edge
    logic [3:0] m1 = 0, m2 = 0, m3 = 0;
    logic [7:0] mstat = 0, men = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m1 = 0; m2 = 0; m3 = 0; mstat = 0; men = 0;
        end else begin
            logic [7:0] nx;
            nx = mstat;
            if (wr && addr == 2'd0) nx = nx & ~(wdata & 8'h33);
            nx = nx | map_bits(m2 ^ m3);
            mstat = nx;
            if (wr && addr == 2'd1) men = wdata & 8'h33;
            m3 = m2; m2 = m1; m1 = pins;
        end
    end

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        return (a == 2'd0) ? mstat : (a == 2'd1) ? men : 8'h00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk(addr == 2'd0 ? "R2" : addr == 2'd1 ? "R7" : "R10", rdata, exp_read(addr));
        chk("R8", {7'd0, smi_n}, {7'd0, ~|(mstat & men)});
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1; tick(); wr = 0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
        addr = a; #1; chk(req, rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rd("R1", 2'd0, 8'h00);
        rd("R1", 2'd1, 8'h00);
        chk("R1", {7'd0, smi_n}, 8'h01);
        rst_n = 1;
        tick();

        wreg(2'd1, 8'hFF);
        rd("R7", 2'd1, 8'h33);

        // rising edge on pin 0, latency check
        addr = 0; pins = 4'b0001;
        tick(); tick();
        chk("R4", rdata, 8'h00);
        tick();
        chk("R4", rdata, 8'h01);
        chk("R8", {7'd0, smi_n}, 8'h00);

        wreg(2'd0, 8'h00);
        rd("R5", 2'd0, 8'h01);
        wreg(2'd0, 8'hFF);
        rd("R5", 2'd0, 8'h00);

        // pin 0 falls, pin 3 rises
        pins = 4'b1000;
        repeat (3) tick();
        rd("R3", 2'd0, 8'h21);
        wreg(2'd0, 8'h21);
        rd("R5", 2'd0, 8'h00);

        // set wins over clear in the detection cycle
        pins = 4'b1010;
        tick(); tick();
        wreg(2'd0, 8'hFF);
        rd("R9", 2'd0, 8'h02);

        // unmapped addresses
        wreg(2'd2, 8'hFF);
        wreg(2'd3, 8'hFF);
        rd("R10", 2'd2, 8'h00);
        rd("R10", 2'd3, 8'h00);
        rd("R10", 2'd1, 8'h33);
        rd("R10", 2'd0, 8'h02);

        // enable masking
        wreg(2'd1, 8'h01);
        chk("R8", {7'd0, smi_n}, 8'h01);
        wreg(2'd1, 8'hCE);
        rd("R6", 2'd1, 8'h02);
        chk("R8", {7'd0, smi_n}, 8'h00);
        wreg(2'd0, 8'hCC);
        rd("R6", 2'd0, 8'h02);

        // pin 2 toggle to bit 4
        pins = 4'b1110;
        repeat (3) tick();
        rd("R2", 2'd0, 8'h12);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            for (int b = 0; b < 4; b++)
                if ($urandom_range(0, 9) == 0) pins[b] = ~pins[b];
            addr  = 2'($urandom_range(0, 3));
            wr    = ($urandom_range(0, 3) == 0);
            wdata = 8'($urandom);
            tick();
        end
        wr = 0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule